// File: doc/BRIEF.md
# Byte-Wide Host Data Port

This block connects an 8-bit host bus to a 24-bit word-oriented processor core. The host bus has no clock of its own. The host moves whole 24-bit words through the port one byte at a time, using three transmit byte registers and three receive byte registers; each set is ordered high, middle, low. Status flags tell the host when it may write and when a word is waiting to be read. A command register lets the host raise an interrupt in the core that carries a vector. The vector is locked while a command is outstanding.

The core side runs on the block clock. It has a word-wide receive register with a valid flag and a take strobe, a word-wide transmit input with a load strobe and a ready flag, and an interrupt request with a vector and an acknowledge. The host chip-select, read and write strobes each pass through a two-flop synchronizer. A write takes effect when its synchronized strobe asserts. A read side effect takes effect when its synchronized strobe deasserts. Address and data must therefore stay stable from the start of a strobe until three clock cycles after it ends.

Three small state machines do the work:
- **Transmit path.** `TX_OPEN` moves to `TX_HELD` when the low byte is written. `TX_HELD` moves back to `TX_OPEN` when the word transfers into a free core register.
- **Receive path.** `RX_VACANT` moves to `RX_LOADED` when the core loads a word. `RX_LOADED` moves back to `RX_VACANT` when the host finishes reading the low byte.
- **Command unit.** `CMD_IDLE` moves to `CMD_RAISED` when the host writes the command register with the command bit set. `CMD_RAISED` moves back to `CMD_IDLE` when the core acknowledges.

Top module: `host_byte_port`

## Requirements
- R1: After synchronous reset:
  - the transmit-empty flag is set;
  - the receive-full flag, the command bit, `core_irq` and `core_rx_valid` are clear;
  - the port is disabled;
  - all data registers are zero;
  - `core_tx_ready` is high.
- R2: Control register at address 0, bit 0 is the port enable. While the enable is clear:
  - host writes to addresses 2, 5, 6 and 7 have no effect;
  - host reads of those addresses return zero and have no side effect.
- R3: Status register at address 1 (read only):
  - bit 0 is receive-full;
  - bit 1 is transmit-empty;
  - bit 2 is command-pending;
  - all other bits read zero.
- R4: The host writes a word to address 5 (high byte), address 6 (middle byte) and address 7 (low byte). Writing the low byte commits the word `{high, middle, low}` and clears transmit-empty.
- R5: A committed word moves into `core_rx_word` on the first cycle in which the core register holds no unread word. `core_rx_valid` then sets and transmit-empty sets again. While an earlier word is still unread, the transfer waits until `core_rx_take` frees the register.
- R6: Host writes to addresses 5, 6 and 7 while transmit-empty is clear are ignored. The committed word is not altered.
- R7: A `core_tx_load` pulse while `core_tx_ready` is high loads `core_tx_word` into the receive bytes and sets receive-full. Reads of addresses 5, 6 and 7 then return the high, middle and low bytes.
- R8: A `core_tx_load` pulse while receive-full is set is ignored, and `core_tx_ready` stays low.
- R9: Receive-full clears when a host read of address 7 ends. Reads of addresses 5 and 6 leave it set.
- R10: Command register at address 2: bit 7 is the command bit and bits 6:0 are the vector. A write while the command bit is clear stores the vector. If bit 7 is written as one, the command bit sets, `core_irq` rises and `core_irq_vec` shows the vector. A read returns the command bit and the vector.
- R11: While the command bit is set, host writes to the command register are ignored, so the vector stays stable.
- R12: A `core_irq_ack` pulse while the command bit is set clears the command bit and `core_irq`.
- R13: Each host strobe assertion takes effect exactly once, however many cycles the strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_addr | input | 3 | Host register address |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data for the addressed register |
| core_rx_word | output | 24 | Word delivered to the core |
| core_rx_valid | output | 1 | `core_rx_word` holds an unread word |
| core_rx_take | input | 1 | Core consumes `core_rx_word` |
| core_tx_word | input | 24 | Word offered by the core to the host |
| core_tx_load | input | 1 | Load `core_tx_word` into the receive bytes |
| core_tx_ready | output | 1 | Receive bytes are free for a load |
| core_irq | output | 1 | Host command interrupt request |
| core_irq_vec | output | 7 | Vector that goes with `core_irq` |
| core_irq_ack | input | 1 | Core acknowledges the command |

## Verification
Host-to-core words are tried in several forms:
- all-zero, all-one and mixed byte patterns, which show whether the bytes land in the wrong lanes or are swapped;
- two words back to back with the core holding the first unread, which separates an immediate transfer from one that waits for a free register;
- a low-byte write held for many cycles, which shows whether a level is mistaken for an event.

Core-to-host loads are tried:
- with receive-full set and with it clear;
- with partial reads of the high and middle bytes before the low byte.

Command writes are tried while the command bit is clear and while it is set.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_STAT = 3'd1;
    localparam logic [2:0] ADR_CMD  = 3'd2;
    localparam logic [2:0] ADR_HI   = 3'd5;
    localparam logic [2:0] ADR_MID  = 3'd6;
    localparam logic [2:0] ADR_LO   = 3'd7;

    typedef enum logic {TX_OPEN, TX_HELD}      tx_state_e;
    typedef enum logic {RX_VACANT, RX_LOADED}  rx_state_e;
    typedef enum logic {CMD_IDLE, CMD_RAISED}  cmd_state_e;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_lvl,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[LAST-1:0], async_lvl};
    end

    always_comb begin
        rise = sh_q[LAST-1] & ~sh_q[LAST];
        fall = ~sh_q[LAST-1] & sh_q[LAST];
    end

    // A held strobe yields one event only
    assert_single_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/hbp_tx_path.sv
module hbp_tx_path
    import hbp_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_hi,
    input  logic            wr_mid,
    input  logic            wr_lo,
    input  logic [BW-1:0]   din,
    input  logic            core_take,
    output logic            empty,
    output logic [3*BW-1:0] core_word,
    output logic            core_valid
);
    tx_state_e     state_q, state_d;
    logic [BW-1:0] hi_q, mid_q, lo_q;
    logic          xfer;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_OPEN: if (wr_lo)       state_d = TX_HELD;
            TX_HELD: if (!core_valid) state_d = TX_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_OPEN;
        else     state_q <= state_d;
    end

    always_comb begin
        empty = (state_q == TX_OPEN);
        xfer  = (state_q == TX_HELD) && !core_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q       <= '0;
            mid_q      <= '0;
            lo_q       <= '0;
            core_word  <= '0;
            core_valid <= 1'b0;
        end else begin
            if (state_q == TX_OPEN) begin
                if (wr_hi)  hi_q  <= din;
                if (wr_mid) mid_q <= din;
                if (wr_lo)  lo_q  <= din;
            end
            if (xfer) begin
                core_word  <= {hi_q, mid_q, lo_q};
                core_valid <= 1'b1;
            end else if (core_take && core_valid) begin
                core_valid <= 1'b0;
            end
        end
    end

    assert_commit_clears_empty_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && state_q == TX_OPEN) |=> !empty);
    assert_valid_drops_on_take_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(core_valid) |-> $past(core_take));
    assert_valid_rises_from_held_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(core_valid) |-> $past(state_q == TX_HELD));
    assert_held_bytes_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_HELD && (wr_hi || wr_mid || wr_lo)) |=> $stable({hi_q, mid_q, lo_q}));
endmodule

// File: rtl/hbp_rx_path.sv
module hbp_rx_path
    import hbp_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            core_load,
    input  logic [3*BW-1:0] core_data,
    input  logic            rd_lo_done,
    output logic            full,
    output logic            core_ready,
    output logic [3*BW-1:0] bytes
);
    rx_state_e       state_q, state_d;
    logic [3*BW-1:0] word_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_VACANT: if (core_load)  state_d = RX_LOADED;
            RX_LOADED: if (rd_lo_done) state_d = RX_VACANT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RX_VACANT;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                                      word_q <= '0;
        else if (state_q == RX_VACANT && core_load)   word_q <= core_data;
    end

    always_comb begin
        full       = (state_q == RX_LOADED);
        core_ready = (state_q == RX_VACANT);
        bytes      = word_q;
    end

    assert_load_when_full_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (full && core_load) |=> $stable(word_q));
    assert_full_clears_on_low_read_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(full) |-> $past(rd_lo_done));
endmodule

// File: rtl/hbp_cmd_unit.sv
module hbp_cmd_unit
    import hbp_pkg::*;
#(
    parameter int VW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_cmd,
    input  logic [VW:0]   din,
    input  logic          ack,
    output logic          pending,
    output logic [VW-1:0] vec
);
    cmd_state_e    state_q, state_d;
    logic [VW-1:0] vec_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE:   if (wr_cmd && din[VW]) state_d = CMD_RAISED;
            CMD_RAISED: if (ack)               state_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CMD_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == CMD_IDLE && wr_cmd) vec_q <= din[VW-1:0];
        end
    end

    always_comb begin
        pending = (state_q == CMD_RAISED);
        vec     = vec_q;
    end

    assert_raise_needs_write_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(wr_cmd));
    assert_vector_locked_R11: assert property (@(posedge clk) disable iff (rst)
        pending |=> $stable(vec_q));
    assert_drop_needs_ack_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) |-> $past(ack));
endmodule

// File: rtl/host_byte_port.sv
module host_byte_port
    import hbp_pkg::*;
#(
    parameter int HOST_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_cs_n,
    input  logic                  host_rd_n,
    input  logic                  host_wr_n,
    input  logic [2:0]            host_addr,
    input  logic [HOST_W-1:0]     host_din,
    output logic [HOST_W-1:0]     host_dout,
    output logic [3*HOST_W-1:0]   core_rx_word,
    output logic                  core_rx_valid,
    input  logic                  core_rx_take,
    input  logic [3*HOST_W-1:0]   core_tx_word,
    input  logic                  core_tx_load,
    output logic                  core_tx_ready,
    output logic                  core_irq,
    output logic [HOST_W-2:0]     core_irq_vec,
    input  logic                  core_irq_ack
);
    localparam int VEC_W  = HOST_W - 1;
    localparam int WORD_W = 3 * HOST_W;

    logic wr_rise, wr_fall_unused, rd_rise_unused, rd_fall;
    logic en_q;
    logic wr_hi, wr_mid, wr_lo, wr_cmd, rd_lo_done;
    logic tx_empty, rx_full, cmd_pend;
    logic [WORD_W-1:0] rx_bytes;
    logic [HOST_W-1:0] status_byte;

    hbp_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst(rst),
        .async_lvl(~host_cs_n & ~host_wr_n),
        .rise(wr_rise), .fall(wr_fall_unused)
    );

    hbp_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst(rst),
        .async_lvl(~host_cs_n & ~host_rd_n),
        .rise(rd_rise_unused), .fall(rd_fall)
    );

    always_ff @(posedge clk) begin
        if (rst)                                  en_q <= 1'b0;
        else if (wr_rise && host_addr == ADR_CTRL) en_q <= host_din[0];
    end

    always_comb begin
        wr_hi      = wr_rise && en_q && (host_addr == ADR_HI);
        wr_mid     = wr_rise && en_q && (host_addr == ADR_MID);
        wr_lo      = wr_rise && en_q && (host_addr == ADR_LO);
        wr_cmd     = wr_rise && en_q && (host_addr == ADR_CMD);
        rd_lo_done = rd_fall && en_q && (host_addr == ADR_LO);
    end

    hbp_tx_path #(.BW(HOST_W)) u_tx (
        .clk(clk), .rst(rst),
        .wr_hi(wr_hi), .wr_mid(wr_mid), .wr_lo(wr_lo),
        .din(host_din), .core_take(core_rx_take),
        .empty(tx_empty), .core_word(core_rx_word), .core_valid(core_rx_valid)
    );

    hbp_rx_path #(.BW(HOST_W)) u_rx (
        .clk(clk), .rst(rst),
        .core_load(core_tx_load), .core_data(core_tx_word),
        .rd_lo_done(rd_lo_done),
        .full(rx_full), .core_ready(core_tx_ready), .bytes(rx_bytes)
    );

    hbp_cmd_unit #(.VW(VEC_W)) u_cmd (
        .clk(clk), .rst(rst),
        .wr_cmd(wr_cmd), .din(host_din), .ack(core_irq_ack),
        .pending(cmd_pend), .vec(core_irq_vec)
    );

    always_comb begin
        core_irq    = cmd_pend;
        status_byte = '0;
        status_byte[0] = rx_full;
        status_byte[1] = tx_empty;
        status_byte[2] = cmd_pend;
    end

    always_comb begin
        host_dout = '0;
        case (host_addr)
            ADR_CTRL: host_dout[0] = en_q;
            ADR_STAT: host_dout = status_byte;
            ADR_CMD:  if (en_q) host_dout = {cmd_pend, core_irq_vec};
            ADR_HI:   if (en_q) host_dout = rx_bytes[3*HOST_W-1:2*HOST_W];
            ADR_MID:  if (en_q) host_dout = rx_bytes[2*HOST_W-1:HOST_W];
            ADR_LO:   if (en_q) host_dout = rx_bytes[HOST_W-1:0];
            default:  host_dout = '0;
        endcase
    end

    assert_disabled_no_commit_R2: assert property (@(posedge clk) disable iff (rst)
        (!en_q && tx_empty) |=> tx_empty);
    assert_irq_tracks_pending_R10: assert property (@(posedge clk) disable iff (rst)
        core_irq |-> status_byte[2]);
endmodule

// File: tb/host_byte_port_test.sv
module host_byte_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_din = '0;
    logic [7:0]  host_dout;
    logic [23:0] core_rx_word;
    logic        core_rx_valid;
    logic        core_rx_take = 1'b0;
    logic [23:0] core_tx_word = '0;
    logic        core_tx_load = 1'b0;
    logic        core_tx_ready;
    logic        core_irq;
    logic [6:0]  core_irq_vec;
    logic        core_irq_ack = 1'b0;

    int          n_run = 0, n_fail = 0;
    logic        mon_en = 1'b0;
    logic [23:0] exp_q[$];

    always #2.5 clk = ~clk;

    host_byte_port uut (
        .clk(clk), .rst(rst),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_addr(host_addr), .host_din(host_din), .host_dout(host_dout),
        .core_rx_word(core_rx_word), .core_rx_valid(core_rx_valid), .core_rx_take(core_rx_take),
        .core_tx_word(core_tx_word), .core_tx_load(core_tx_load), .core_tx_ready(core_tx_ready),
        .core_irq(core_irq), .core_irq_vec(core_irq_vec), .core_irq_ack(core_irq_ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d, input int hold = 4);
        @(negedge clk);
        host_addr = a; host_din = d; host_cs_n = 1'b0; host_wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        host_wr_n = 1'b1; host_cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_cs_n = 1'b0; host_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        d = host_dout;
        host_rd_n = 1'b1; host_cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_word(input logic [23:0] w);
        exp_q.push_back(w);
        host_wr(3'd5, w[23:16]);
        host_wr(3'd6, w[15:8]);
        host_wr(3'd7, w[7:0]);
    endtask

    // Scoreboard monitor: consumes core-side words and compares in order
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && core_rx_valid && !core_rx_take) begin
                n_run++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R5/R13 actual=%0h expected=no word", core_rx_word);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    n_run--;
                    check("R4 word order", {8'h0, core_rx_word}, {8'h0, e});
                end
                core_rx_take = 1'b1;
            end else begin
                core_rx_take = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R3 reset state
        host_rd(3'd1, d);
        check("R1 R3 status after reset", {24'h0, d}, 32'h02);
        check("R1 irq", {31'h0, core_irq}, 32'h0);
        check("R1 rx valid", {31'h0, core_rx_valid}, 32'h0);
        check("R1 tx ready", {31'h0, core_tx_ready}, 32'h1);
        host_rd(3'd0, d);
        check("R1 disabled", {24'h0, d}, 32'h0);

        // R2 disabled port
        mon_en = 1'b1;
        host_wr(3'd5, 8'hAA);
        host_wr(3'd7, 8'h11);
        host_wr(3'd2, 8'h85);
        @(negedge clk);
        core_tx_word = 24'h89ABCD; core_tx_load = 1'b1;
        @(negedge clk);
        core_tx_load = 1'b0;
        check("R7 ready low after load", {31'h0, core_tx_ready}, 32'h0);
        host_rd(3'd5, d);
        check("R2 read hidden", {24'h0, d}, 32'h0);
        host_rd(3'd7, d);
        check("R2 low read hidden", {24'h0, d}, 32'h0);
        host_rd(3'd1, d);
        check("R2 R3 status disabled", {24'h0, d}, 32'h03);
        check("R2 no irq", {31'h0, core_irq}, 32'h0);

        host_wr(3'd0, 8'h01);
        host_rd(3'd0, d);
        check("R2 enable set", {24'h0, d}, 32'h01);

        // R7 R8 R9 receive path
        host_rd(3'd5, d);
        check("R7 high byte", {24'h0, d}, 32'h89);
        host_rd(3'd6, d);
        check("R7 middle byte", {24'h0, d}, 32'hAB);
        host_rd(3'd1, d);
        check("R9 still full", {24'h0, d}, 32'h03);
        @(negedge clk);
        core_tx_word = 24'h111111; core_tx_load = 1'b1;
        @(negedge clk);
        core_tx_load = 1'b0;
        host_rd(3'd5, d);
        check("R8 load ignored", {24'h0, d}, 32'h89);
        host_rd(3'd7, d);
        check("R7 low byte", {24'h0, d}, 32'hCD);
        host_rd(3'd1, d);
        check("R9 full cleared", {24'h0, d}, 32'h02);
        check("R9 ready again", {31'h0, core_tx_ready}, 32'h1);

        // R4 R5 transmit path, several patterns
        send_word(24'h123456);
        send_word(24'h000000);
        send_word(24'hFFFFFF);
        send_word(24'hA5C3E1);
        repeat (6) @(negedge clk);
        check("R5 queue drained", exp_q.size(), 32'h0);
        host_rd(3'd1, d);
        check("R4 R5 empty again", {24'h0, d}, 32'h02);

        // R5 wait for free core register, R6 writes while held
        mon_en = 1'b0;
        send_word(24'h3C5A7E);
        check("R5 valid set", {31'h0, core_rx_valid}, 32'h1);
        host_rd(3'd1, d);
        check("R5 empty after transfer", {24'h0, d}, 32'h02);
        send_word(24'h0F1E2D);
        host_rd(3'd1, d);
        check("R5 held while core full", {24'h0, d}, 32'h00);
        check("R5 core word kept", {8'h0, core_rx_word}, 32'h3C5A7E);
        host_wr(3'd5, 8'hFF);
        host_wr(3'd7, 8'hEE);
        mon_en = 1'b1;
        repeat (10) @(negedge clk);
        check("R6 queue drained", exp_q.size(), 32'h0);

        // R13 long strobe commits once
        exp_q.push_back(24'h0F0F0F);
        host_wr(3'd5, 8'h0F);
        host_wr(3'd6, 8'h0F);
        host_wr(3'd7, 8'h0F, 20);
        repeat (10) @(negedge clk);
        check("R13 single commit", exp_q.size(), 32'h0);

        // R10 R11 R12 command
        host_wr(3'd2, 8'hA5);
        check("R10 irq raised", {31'h0, core_irq}, 32'h1);
        check("R10 vector", {25'h0, core_irq_vec}, 32'h25);
        host_wr(3'd2, 8'hB3);
        check("R11 vector locked", {25'h0, core_irq_vec}, 32'h25);
        host_rd(3'd2, d);
        check("R10 cmd readback", {24'h0, d}, 32'hA5);
        host_rd(3'd1, d);
        check("R3 pending bit", {24'h0, d}, 32'h06);
        @(negedge clk);
        core_irq_ack = 1'b1;
        @(negedge clk);
        core_irq_ack = 1'b0;
        check("R12 irq cleared", {31'h0, core_irq}, 32'h0);
        host_wr(3'd2, 8'hB3);
        check("R10 new vector", {25'h0, core_irq_vec}, 32'h33);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule